// File: doc/BRIEF.md
# Dual-Port Test-and-Set Semaphore Memory

This block holds a small array of one-bit cells that two processors share as semaphores. Each processor has its own port with an address, a write data bit, a request strobe and a busy output. A request makes one atomic test-and-set. The port first captures the addressed cell into its own sample register and marks the address as owned. On the next clock edge it writes its data bit into the cell, but only if the captured value was zero. A processor that reads a zero in its sample output has taken the semaphore. A processor that reads a one finds the semaphore already held, and the cell is left as it was.

While a port owns an address, the other port cannot get at that cell. If the other port requests the same address, it sees busy and waits with its request held. It is granted on its own once the owner lets go. When both ports request the same free address in the same cycle, port 0 takes it. Requests to different addresses are served in parallel. A port keeps ownership for as long as its request stays high. Ownership ends on the clock edge that sees the request low.

Top module: `tas_sema_mem`

## Requirements
- R1: After reset every cell holds 0, and on both ports busy, owned and sample are 0.
- R2: A request that is not busy, from a port that owns nothing, sets that port's owned output on the next clock edge. On that same edge the sample output takes the value the addressed cell held before the operation.
- R3: If the captured sample is 0, the port's data bit is written to the owned cell on the edge after the capture. If the sample is 1, the cell keeps its value.
- R4: A port whose request targets the address the other port owns sees busy high in the same cycle and is not granted. This holds in both directions.
- R5: No port can change or capture a cell between the other port's capture and write of that cell. A waiting port therefore samples the value the owner left behind.
- R6: When both ports request the same free address in the same cycle, port 0 is granted and port 1 sees busy.
- R7: Requests from the two ports to different addresses are both granted in the same cycle, and neither port sees busy.
- R8: Owned clears on the clock edge at which the owner's request is low. The other port's busy drops in the cycle after that edge, and a port still waiting is granted on the following edge.
- R9: While a port owns an address, changes on its address and data inputs are ignored. The sample stays constant, and the write uses the address and data captured at the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_req | input | 1 | Port 0 test-and-set request |
| p0_addr | input | AW | Port 0 cell address |
| p0_wdata | input | 1 | Port 0 value to set |
| p0_busy | output | 1 | Port 0 request blocked by port 1 |
| p0_sample | output | 1 | Port 0 captured cell value |
| p0_owned | output | 1 | Port 0 holds an address |
| p1_req | input | 1 | Port 1 test-and-set request |
| p1_addr | input | AW | Port 1 cell address |
| p1_wdata | input | 1 | Port 1 value to set |
| p1_busy | output | 1 | Port 1 request blocked by port 0 |
| p1_sample | output | 1 | Port 1 captured cell value |
| p1_owned | output | 1 | Port 1 holds an address |

## Verification
A wrong cell value stays hidden until a later operation on that address captures it. That sample shows on the edge after the grant, so every write is read back through a second test-and-set. A wrong owner flag or captured address shows up in the same cycle as a missing or false busy on the other port. It also shows as owned failing to clear one edge after the request falls. The reference model therefore predicts busy, owned and sample in every cycle. The same-address races are driven directly: the simultaneous request, the request during the capture-to-write gap, and the hand-over on release.

// File: rtl/tas_pkg.sv
package tas_pkg;
    localparam int TAS_AW    = 4;
    localparam int TAS_PORTS = 2;
endpackage

// File: rtl/tas_store.sv
module tas_store #(
    parameter int AW = 4,
    parameter int NP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          wr_en,
    input  logic [NP-1:0][AW-1:0]  wr_addr,
    input  logic [NP-1:0]          wr_data,
    input  logic [NP-1:0][AW-1:0]  rd_addr,
    output logic [NP-1:0]          rd_bit
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NP; p++) begin
            if (wr_en[p]) mem_d[wr_addr[p]] = wr_data[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        assign rd_bit[g] = mem_q[rd_addr[g]];

        // R3: a write lands in the addressed cell
        p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> mem_q[$past(wr_addr[g])] == $past(wr_data[g]));
    end

    // R5: two writers never target one cell at once
    p_single_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en[0] && wr_en[1] && wr_addr[0] == wr_addr[1]));
endmodule

// File: rtl/tas_port_unit.sv
module tas_port_unit #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          wdata,
    input  logic          blocked,
    input  logic          rd_bit,
    output logic          owned,
    output logic          sample,
    output logic [AW-1:0] own_addr,
    output logic          wr_en,
    output logic          wr_data
);
    typedef struct packed {
        logic          flag;
        logic          sample;
        logic          pend;
        logic [AW-1:0] addr;
        logic          data;
    } unit_t;

    unit_t st_d, st_q;
    logic  grant_c;

    always_comb begin
        st_d    = st_q;
        grant_c = req && !st_q.flag && !blocked;
        if (st_q.pend)            st_d.pend = 1'b0;
        if (st_q.flag && !req)    st_d.flag = 1'b0;
        if (grant_c) begin
            st_d.flag   = 1'b1;
            st_d.sample = rd_bit;
            st_d.pend   = 1'b1;
            st_d.addr   = addr;
            st_d.data   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owned    = st_q.flag;
    assign sample   = st_q.sample;
    assign own_addr = st_q.addr;
    assign wr_en    = st_q.pend && !st_q.sample;
    assign wr_data  = st_q.data;

    // R8: ownership ends on the edge that sees the request low
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !req) |=> !st_q.flag);

    // R9: held ownership keeps sample and address
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && req) |=> (st_q.flag && $stable(st_q.sample) && $stable(st_q.addr)));

    // R3: one write per operation at most
    p_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/tas_sema_mem.sv
module tas_sema_mem
    import tas_pkg::*;
#(
    parameter int AW = TAS_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_req,
    input  logic [AW-1:0] p0_addr,
    input  logic          p0_wdata,
    output logic          p0_busy,
    output logic          p0_sample,
    output logic          p0_owned,
    input  logic          p1_req,
    input  logic [AW-1:0] p1_addr,
    input  logic          p1_wdata,
    output logic          p1_busy,
    output logic          p1_sample,
    output logic          p1_owned
);
    localparam int NP = TAS_PORTS;

    logic [NP-1:0]         req_v, wdata_v, blk_v, owned_v, sample_v;
    logic [NP-1:0]         wr_en_v, wr_data_v, rd_bit_v;
    logic [NP-1:0][AW-1:0] addr_v, own_addr_v;
    logic                  blk0, blk1, claim0;

    assign req_v   = {p1_req, p0_req};
    assign wdata_v = {p1_wdata, p0_wdata};
    assign addr_v  = {p1_addr, p0_addr};

    // port 0 wins a same-cycle tie, so its claim blocks port 1
    always_comb begin
        blk0   = owned_v[1] && (own_addr_v[1] == p0_addr);
        claim0 = p0_req && !owned_v[0] && !blk0;
        blk1   = (owned_v[0] && (own_addr_v[0] == p1_addr))
               || (claim0 && (p0_addr == p1_addr));
    end

    assign blk_v = {blk1, blk0};

    for (genvar i = 0; i < NP; i++) begin : g_port
        tas_port_unit #(.AW(AW)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_v[i]),
            .addr     (addr_v[i]),
            .wdata    (wdata_v[i]),
            .blocked  (blk_v[i]),
            .rd_bit   (rd_bit_v[i]),
            .owned    (owned_v[i]),
            .sample   (sample_v[i]),
            .own_addr (own_addr_v[i]),
            .wr_en    (wr_en_v[i]),
            .wr_data  (wr_data_v[i])
        );
    end

    tas_store #(.AW(AW), .NP(NP)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_v),
        .wr_addr (own_addr_v),
        .wr_data (wr_data_v),
        .rd_addr (addr_v),
        .rd_bit  (rd_bit_v)
    );

    assign p0_busy   = p0_req && !owned_v[0] && blk0;
    assign p1_busy   = p1_req && !owned_v[1] && blk1;
    assign p0_sample = sample_v[0];
    assign p1_sample = sample_v[1];
    assign p0_owned  = owned_v[0];
    assign p1_owned  = owned_v[1];

    // R5: never two owners of one address
    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_owned && p1_owned && own_addr_v[0] == own_addr_v[1]));

    // R4: a request on the owned address is held off
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && p0_owned && own_addr_v[0] == p1_addr) |-> p1_busy);

    // R6: tie on a free address goes to port 0
    p_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && p1_req && p0_addr == p1_addr && !p0_owned && !p1_owned)
        |-> (!p0_busy && p1_busy));

    // R7: different addresses never block
    p_parallel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_addr != p1_addr && !p0_owned && !p1_owned) |-> (!p0_busy && !p1_busy));
endmodule

// File: tb/tas_sema_mem_bench.sv
`timescale 1ns/1ps
module tas_sema_mem_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c0 = 0, c1 = 0, d0 = 0, d1 = 0;
    logic [3:0] a0 = '0, a1 = '0;
    logic b0, b1, s0, s1, o0, o1;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    tas_sema_mem u_tas_sema_mem (
        .clk(clk), .rst_n(rst_n),
        .p0_req(c0), .p0_addr(a0), .p0_wdata(d0),
        .p0_busy(b0), .p0_sample(s0), .p0_owned(o0),
        .p1_req(c1), .p1_addr(a1), .p1_wdata(d1),
        .p1_busy(b1), .p1_sample(s1), .p1_owned(o1)
    );

    // behavioural reference model
    bit       m_mem [16];
    bit       m_fl [2];
    bit       m_sm [2];
    bit       m_pd [2];
    bit       m_dt [2];
    bit [3:0] m_ad [2];

    function automatic bit blocked_of(int p);
        bit tie;
        if (p == 0) return m_fl[1] && m_ad[1] == a0;
        tie = c0 && !m_fl[0] && !(m_fl[1] && m_ad[1] == a0) && a0 == a1;
        return (m_fl[0] && m_ad[0] == a1) || tie;
    endfunction

    function automatic bit busy_of(int p);
        if (p == 0) return c0 && !m_fl[0] && blocked_of(0);
        return c1 && !m_fl[1] && blocked_of(1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            for (int p = 0; p < 2; p++) begin
                m_fl[p] = 0; m_sm[p] = 0; m_pd[p] = 0; m_dt[p] = 0; m_ad[p] = '0;
            end
        end else begin
            bit g0, g1, r0, r1;
            g0 = c0 && !m_fl[0] && !blocked_of(0);
            g1 = c1 && !m_fl[1] && !blocked_of(1);
            r0 = m_mem[a0];
            r1 = m_mem[a1];
            for (int p = 0; p < 2; p++) begin
                if (m_pd[p] && !m_sm[p]) m_mem[m_ad[p]] = m_dt[p];
                m_pd[p] = 0;
            end
            if (m_fl[0] && !c0) m_fl[0] = 0;
            if (m_fl[1] && !c1) m_fl[1] = 0;
            if (g0) begin m_fl[0] = 1; m_sm[0] = r0; m_pd[0] = 1; m_ad[0] = a0; m_dt[0] = d0; end
            if (g1) begin m_fl[1] = 1; m_sm[1] = r1; m_pd[1] = 1; m_ad[1] = a1; m_dt[1] = d1; end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 busy0 model", b0, busy_of(0));
            chk("R4 busy1 model", b1, busy_of(1));
            chk("R8 owned0 model", o0, m_fl[0]);
            chk("R8 owned1 model", o1, m_fl[1]);
            chk("R2 sample0 model", s0, m_sm[0]);
            chk("R2 sample1 model", s1, m_sm[1]);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic look();
        #1;
    endtask

    task automatic go(int p, int a, bit d);
        if (p == 0) begin c0 = 1; a0 = 4'(a); d0 = d; end
        else        begin c1 = 1; a1 = 4'(a); d1 = d; end
    endtask

    task automatic stop(int p);
        if (p == 0) c0 = 0; else c1 = 0;
    endtask

    // non-destructive read: test-and-set with data 0
    task automatic rd(int p, int a, output bit v);
        go(p, a, 0);
        tick();
        look();
        v = (p == 0) ? s0 : s1;
        stop(p);
        tick();
        tick();
    endtask

    initial begin
        bit v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        look();
        chk("R1 busy0", b0, 0);   chk("R1 busy1", b1, 0);
        chk("R1 owned0", o0, 0);  chk("R1 owned1", o1, 0);
        chk("R1 sample0", s0, 0); chk("R1 sample1", s1, 0);
        tick();
        rd(0, 5, v); chk("R1 cell5 clear", v, 0);

        // capture of a clear cell, then set
        go(0, 3, 1); tick(); look();
        chk("R2 owned0", o0, 1); chk("R2 sample0 clear", s0, 0);
        stop(0); tick(); tick();
        rd(1, 3, v); chk("R3 cell3 set", v, 1);

        // set cell: data 0 must not clear it
        go(0, 3, 0); tick(); look();
        chk("R2 sample0 set", s0, 1);
        stop(0); tick(); tick();
        rd(1, 3, v); chk("R3 no write when set", v, 1);

        // conflict and hand-over
        go(0, 7, 1); tick();
        go(1, 7, 0); look();
        chk("R4 busy1 on owned addr", b1, 1);
        tick(); look();
        chk("R4 owned1 held off", o1, 0);
        stop(0); look();
        chk("R8 busy1 still high", b1, 1);
        tick(); look();
        chk("R8 owned0 cleared", o0, 0);
        chk("R8 busy1 dropped", b1, 0);
        tick(); look();
        chk("R8 owned1 granted", o1, 1);
        chk("R5 sample1 sees owner write", s1, 1);
        stop(1); tick(); tick();

        // reverse direction
        go(1, 8, 1); tick();
        go(0, 8, 0); look();
        chk("R4 busy0 on owned addr", b0, 1);
        stop(0); stop(1); tick(); tick();

        // same-cycle tie
        go(0, 9, 1); go(1, 9, 0); look();
        chk("R6 busy0 low", b0, 0); chk("R6 busy1 high", b1, 1);
        tick(); look();
        chk("R6 owned0", o0, 1); chk("R6 owned1", o1, 0);
        stop(0); stop(1); tick(); tick();
        rd(1, 9, v); chk("R6 winner data", v, 1);

        // different addresses in parallel
        go(0, 10, 1); go(1, 11, 1); look();
        chk("R7 busy0", b0, 0); chk("R7 busy1", b1, 0);
        tick(); look();
        chk("R7 owned0", o0, 1); chk("R7 owned1", o1, 1);
        stop(0); stop(1); tick(); tick();
        rd(0, 11, v); chk("R7 cell11", v, 1);
        rd(1, 10, v); chk("R7 cell10", v, 1);

        // input changes while owning are ignored
        go(0, 12, 1); tick();
        go(0, 13, 0); tick(); look();
        chk("R9 owned held", o0, 1); chk("R9 sample held", s0, 0);
        stop(0); tick(); tick();
        rd(1, 12, v); chk("R9 captured addr written", v, 1);
        rd(1, 13, v); chk("R9 new addr untouched", v, 0);

        // request during capture-to-write gap
        go(0, 14, 1); tick();
        stop(0); go(1, 14, 0); look();
        chk("R5 busy1 in gap", b1, 1);
        tick(); look();
        chk("R5 busy1 after release", b1, 0);
        tick(); look();
        chk("R5 sample1 after gap", s1, 1);
        stop(1); tick(); tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule